// File: doc/BRIEF.md
# XOR Sprite Draw Engine

This block draws a small monochrome sprite into a 64 by 32 frame buffer that holds one bit per pixel. A draw starts with a one-cycle `start` request. The request carries a column, a row, a row count and a sprite base address. The engine then fetches one sprite byte for each row through a synchronous memory read port. It combines each byte into the frame buffer by exclusive-OR, so drawing the same sprite twice at the same place erases it.

When the draw finishes, the engine reports whether any lit pixel was switched off. Game-style software uses this flag to detect overlap between objects. Starting coordinates that lie off the screen wrap onto it. Sprite pixels that run past the right or bottom edge are dropped. The frame buffer can be inspected one row at a time through a combinational row read port.

Top module: `xor_blit_engine`

## Requirements
- R1: After reset, `busy`, `done` and `collision` are 0 and every frame-buffer row reads as all zeros.
- R2: A draw is accepted on a rising edge where `start` is 1 and `busy` is 0. The start column is `pos_x` modulo 64 and the start row is `pos_y` modulo 32.
- R3: Sprite row r is read from address (`base_addr` + r) modulo 4096. `mem_rd_en` is 1 for one cycle with that address, the data is taken from `mem_rd_data` one cycle later, and rows are fetched in order from r = 0.
- R4: Bit k of `fb_row_data` is column k of the row chosen by `fb_row_sel`. In a sprite byte, bit 7 lands on the start column and bit 0 lands on the start column plus 7.
- R5: Each sprite bit of 1 inverts its target pixel. A sprite bit of 0 leaves its pixel unchanged, and pixels outside the sprite are never modified.
- R6: A sprite pixel whose column would be 64 or more is not drawn and does not wrap.
- R7: A sprite row whose screen row would be 32 or more is not drawn and does not wrap.
- R8: `collision` is cleared when a draw is accepted. It becomes 1 if any sprite bit of 1 lands on a pixel that was already 1, and it then holds its value until the next accepted draw. A 0 bit never sets it.
- R9: `done` is 1 for exactly one cycle, on the 2N-th rising edge after the accepting edge, where N is `rows` (counting the accepting edge as edge 0). `busy` is 1 from the accepting edge through the `done` cycle and is 0 one cycle later.
- R10: A `start` that arrives while `busy` is 1 is ignored. The draw in progress finishes unchanged and no new draw follows it.
- R11: A draw with `rows` = 0 changes no pixel, fetches nothing, and leaves `collision` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Draw request |
| pos_x | input | 8 | Start column, wrapped modulo 64 |
| pos_y | input | 8 | Start row, wrapped modulo 32 |
| rows | input | 4 | Number of sprite rows (0 to 15) |
| base_addr | input | 12 | Address of the first sprite byte |
| mem_rd_en | output | 1 | Sprite memory read strobe |
| mem_rd_addr | output | 12 | Sprite memory read address |
| mem_rd_data | input | 8 | Sprite byte, valid the cycle after the strobe |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle end-of-draw pulse |
| collision | output | 1 | A lit pixel was turned off by the last draw |
| fb_row_sel | input | 5 | Row selected for inspection |
| fb_row_data | output | 64 | Pixels of the selected row, bit k = column k |

## Verification
The assertions assume that the sprite memory returns the addressed byte exactly one cycle after `mem_rd_en`, with no wait states. A collision counted from a byte delivered late would otherwise be blamed on the engine. The bench memory is a plain 256-byte array read on the clock edge, so that latency always holds. The request fields matter only on the accepting edge, and the bench deliberately changes them while a draw runs to show that they are ignored. The pixel model in the bench walks the sprite one pixel at a time, with its own wrap, clip and collision rules.

// File: rtl/xbe_pkg.sv
package xbe_pkg;

  // Draw sequencer states. Each sprite row costs one FETCH and one APPLY.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_APPLY = 2'd2,
    ST_DONE  = 2'd3
  } xbe_state_e;

endpackage

// File: rtl/xbe_ctrl.sv
module xbe_ctrl
  import xbe_pkg::*;
#(
  parameter int SCR_H  = 32,
  parameter int X_W    = 6,
  parameter int Y_W    = 5,
  parameter int CRD_W  = 8,
  parameter int N_W    = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CRD_W-1:0]  pos_x,
  input  logic [CRD_W-1:0]  pos_y,
  input  logic [N_W-1:0]    rows,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [X_W-1:0]    org_x,
  output logic [Y_W-1:0]    row_idx,
  output logic              row_we,
  output logic              accept
);

  // Row sum needs room for the largest start row plus the largest row count.
  localparam int YS_W = ((Y_W > N_W) ? Y_W : N_W) + 1;

  xbe_state_e        state_q;
  logic [X_W-1:0]    x_q;
  logic [Y_W-1:0]    y_q;
  logic [N_W-1:0]    n_q;
  logic [N_W-1:0]    r_q;
  logic [ADDR_W-1:0] i_q;

  // Screen row of the sprite row being processed, before clipping.
  function automatic logic [YS_W-1:0] screen_row(input logic [Y_W-1:0] y0,
                                                 input logic [N_W-1:0] r);
    return YS_W'(y0) + YS_W'(r);
  endfunction

  // Address of sprite row r, wrapping within the address space.
  function automatic logic [ADDR_W-1:0] sprite_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [N_W-1:0]    r);
    return base + ADDR_W'(r);
  endfunction

  logic [YS_W-1:0] cur_y;
  logic            row_ok;
  logic            last_row;

  assign cur_y    = screen_row(y_q, r_q);
  assign row_ok   = cur_y < YS_W'(SCR_H);
  assign last_row = ((N_W+1)'(r_q) + (N_W+1)'(1)) == (N_W+1)'(n_q);

  assign accept      = (state_q == ST_IDLE) && start;
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign mem_rd_en   = (state_q == ST_FETCH);
  assign mem_rd_addr = sprite_addr(i_q, r_q);
  assign org_x       = x_q;
  assign row_idx     = cur_y[Y_W-1:0];
  assign row_we      = (state_q == ST_APPLY) && row_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      n_q     <= '0;
      r_q     <= '0;
      i_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            x_q     <= X_W'(pos_x);
            y_q     <= Y_W'(pos_y);
            n_q     <= rows;
            i_q     <= base_addr;
            r_q     <= '0;
            state_q <= (rows == '0) ? ST_DONE : ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_APPLY;
        ST_APPLY: begin
          r_q     <= r_q + N_W'(1);
          state_q <= last_row ? ST_DONE : ST_FETCH;
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: done lasts exactly one cycle.
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: busy cannot drop before done has been shown.
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R10: a request while busy leaves the latched draw untouched.
  a_r10_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(x_q) && $stable(y_q) && $stable(n_q) && $stable(i_q)));

  // R3: consecutive fetches of one draw step the address by one.
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && ($past(state_q) == ST_APPLY)) |-> (mem_rd_addr == $past(mem_rd_addr, 2) + ADDR_W'(1)));

  // R11: a zero-row draw goes straight to done without fetching.
  a_r11_empty_draw: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (rows == '0)) |=> (done && !mem_rd_en));

endmodule

// File: rtl/xbe_row_mask.sv
module xbe_row_mask #(
  parameter int SCR_W = 64,
  parameter int X_W   = 6,
  parameter int SPR_W = 8
) (
  input  logic [SPR_W-1:0] sprite_byte,
  input  logic [X_W-1:0]   org_x,
  output logic [SCR_W-1:0] mask
);

  // Each sprite bit lane finds its screen column and whether it is on screen.
  logic [X_W-1:0] lane_col [SPR_W];
  logic [SPR_W-1:0] lane_ok;

  // Column of lane c; one extra bit shows running off the right edge.
  function automatic logic [X_W:0] lane_column(input logic [X_W-1:0] x0, input int c);
    return (X_W+1)'(x0) + (X_W+1)'(c);
  endfunction

  genvar c;
  generate
    for (c = 0; c < SPR_W; c++) begin : g_lane
      logic [X_W:0] col;
      assign col         = lane_column(org_x, c);
      assign lane_ok[c]  = col < (X_W+1)'(SCR_W);
      assign lane_col[c] = col[X_W-1:0];
    end
  endgenerate

  // Most significant sprite bit maps to the leftmost column.
  always_comb begin
    mask = '0;
    for (int k = 0; k < SPR_W; k++) begin
      if (lane_ok[k] && sprite_byte[SPR_W-1-k]) mask[lane_col[k]] = 1'b1;
    end
  end

endmodule

// File: rtl/xbe_framebuf.sv
module xbe_framebuf #(
  parameter int SCR_W = 64,
  parameter int SCR_H = 32,
  parameter int Y_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [Y_W-1:0]   wr_row,
  input  logic [SCR_W-1:0] mask,
  input  logic             clr_coll,
  input  logic [Y_W-1:0]   rd_sel,
  output logic [SCR_W-1:0] rd_data,
  output logic             coll,
  output logic             erase_evt
);

  logic [SCR_H-1:0][SCR_W-1:0] fb_q;
  logic                        coll_q;
  logic [SCR_W-1:0]            old_row;

  // Lit pixels that a set sprite bit is about to switch off.
  function automatic logic any_erase(input logic [SCR_W-1:0] cur,
                                     input logic [SCR_W-1:0] m);
    return |(cur & m);
  endfunction

  assign old_row   = fb_q[wr_row];
  assign erase_evt = we && any_erase(old_row, mask);
  assign coll      = coll_q;

  // Read port: a power-of-two height needs no range guard.
  generate
    if (SCR_H == (1 << Y_W)) begin : g_rd_full
      assign rd_data = fb_q[rd_sel];
    end else begin : g_rd_guard
      assign rd_data = (rd_sel < Y_W'(SCR_H)) ? fb_q[rd_sel] : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_q   <= '0;
      coll_q <= 1'b0;
    end else begin
      if (we) fb_q[wr_row] <= old_row ^ mask;
      if (clr_coll)       coll_q <= 1'b0;
      else if (erase_evt) coll_q <= 1'b1;
    end
  end

  // R5: without a write strobe no pixel anywhere changes.
  a_r5_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(fb_q));

  // R8: an accepted draw starts with the flag cleared.
  a_r8_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    clr_coll |=> !coll_q);

  // R8: the flag only rises after a lit pixel was erased.
  a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_q) |-> $past(erase_evt));

endmodule

// File: rtl/xor_blit_engine.sv
module xor_blit_engine #(
  parameter int SCR_W  = 64,
  parameter int SCR_H  = 32,
  parameter int CRD_W  = 8,
  parameter int N_W    = 4,
  parameter int ADDR_W = 12,
  parameter int SPR_W  = 8,
  parameter int X_W    = $clog2(SCR_W),
  parameter int Y_W    = $clog2(SCR_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CRD_W-1:0]  pos_x,
  input  logic [CRD_W-1:0]  pos_y,
  input  logic [N_W-1:0]    rows,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [SPR_W-1:0]  mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              collision,
  input  logic [Y_W-1:0]    fb_row_sel,
  output logic [SCR_W-1:0]  fb_row_data
);

  // Internal events, named for the assertions.
  logic [X_W-1:0]   org_x;
  logic [Y_W-1:0]   row_idx;
  logic             row_we;
  logic             accept;
  logic [SCR_W-1:0] row_mask;
  logic             erase_evt;

  xbe_ctrl #(
    .SCR_H(SCR_H), .X_W(X_W), .Y_W(Y_W), .CRD_W(CRD_W),
    .N_W(N_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pos_x(pos_x), .pos_y(pos_y), .rows(rows), .base_addr(base_addr),
    .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .org_x(org_x), .row_idx(row_idx), .row_we(row_we), .accept(accept)
  );

  xbe_row_mask #(
    .SCR_W(SCR_W), .X_W(X_W), .SPR_W(SPR_W)
  ) u_mask (
    .sprite_byte(mem_rd_data), .org_x(org_x), .mask(row_mask)
  );

  xbe_framebuf #(
    .SCR_W(SCR_W), .SCR_H(SCR_H), .Y_W(Y_W)
  ) u_fb (
    .clk(clk), .rst_n(rst_n),
    .we(row_we), .wr_row(row_idx), .mask(row_mask),
    .clr_coll(accept),
    .rd_sel(fb_row_sel), .rd_data(fb_row_data),
    .coll(collision), .erase_evt(erase_evt)
  );

  // R6: clipping can drop sprite pixels but never add any.
  a_r6_clip_count: assert property (@(posedge clk) disable iff (!rst_n)
    row_we |-> ($countones(row_mask) <= $countones(mem_rd_data)));

  // R8: an erase can only happen while a draw is running.
  a_r8_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
    erase_evt |-> (busy && !done));

  // R3: the memory is read only inside a draw.
  a_r3_fetch_in_draw: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (busy && !done));

endmodule

// File: tb/xor_blit_engine_tb_top.sv
`timescale 1ns/1ps
module xor_blit_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  pos_x = '0;
  logic [7:0]  pos_y = '0;
  logic [3:0]  rows = '0;
  logic [11:0] base_addr = '0;
  logic        mem_rd_en;
  logic [11:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        busy, done, collision;
  logic [4:0]  fb_row_sel = '0;
  logic [63:0] fb_row_data;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem [256];
  logic [63:0] model [32];

  always #4 clk = ~clk;

  // Sprite memory: one cycle of read latency, aliased to 256 bytes.
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];

  xor_blit_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pos_x(pos_x), .pos_y(pos_y), .rows(rows), .base_addr(base_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .busy(busy), .done(done), .collision(collision),
    .fb_row_sel(fb_row_sel), .fb_row_data(fb_row_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R1 R4 R5 R6 R7: whole frame against the pixel model.
  task automatic compare_frame(input string req);
    int bad_row = -1;
    logic [63:0] act = '0;
    for (int row = 0; row < 32; row++) begin
      fb_row_sel = 5'(row);
      #1;
      if (bad_row < 0 && fb_row_data !== model[row]) begin
        bad_row = row;
        act = fb_row_data;
      end
    end
    if (bad_row < 0) check(1'b1, req, "frame", '0, '0);
    else check(1'b0, req, $sformatf("frame row %0d", bad_row), act, model[bad_row]);
  endtask

  task automatic draw(input int x, input int y, input int n, input int addr,
                      input bit interfere);
    bit exp_coll = 1'b0;
    int edges = 0;
    int fidx = 0;
    bit addr_bad = 1'b0;
    // Pixel-by-pixel expectation: wrap start, clip edges, XOR, note erasures.
    for (int r = 0; r < n; r++) begin
      int yy = (y % 32) + r;
      logic [7:0] b = mem[(addr + r) & 255];
      if (yy < 32) begin
        for (int c = 0; c < 8; c++) begin
          int xx = (x % 64) + c;
          if (xx < 64 && b[7-c]) begin
            if (model[yy][xx]) exp_coll = 1'b1;
            model[yy][xx] = ~model[yy][xx];
          end
        end
      end
    end
    @(negedge clk);
    start = 1'b1; pos_x = 8'(x); pos_y = 8'(y); rows = 4'(n); base_addr = 12'(addr);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9", "busy after accept", 64'(busy), 64'd1);
    while (!done && edges < 200) begin
      if (mem_rd_en) begin
        if (mem_rd_addr !== 12'((addr + fidx) & 12'hFFF)) addr_bad = 1'b1;
        fidx++;
      end
      if (interfere && edges == 1) begin
        // R10: junk request in mid-draw
        start = 1'b1; pos_x = 8'(x + 17); pos_y = 8'(y + 3);
        rows = 4'd15; base_addr = 12'(addr + 5);
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    start = 1'b0;
    check(edges == 2 * n, "R9", "edges to done", 64'(edges), 64'(2 * n));
    check(!addr_bad && fidx == n, "R3", "fetch addresses/count", 64'(fidx), 64'(n));
    check(collision === exp_coll, "R8", "collision at done", 64'(collision), 64'(exp_coll));
    if (interfere) begin
      // R10: request during the done cycle is also dropped
      start = 1'b1; pos_x = 8'(x + 9); rows = 4'd3;
    end
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b0 && done === 1'b0, interfere ? "R10" : "R9", "idle after done",
          {62'd0, busy, done}, 64'd0);
    check(collision === exp_coll, "R8", "collision held", 64'(collision), 64'(exp_coll));
    compare_frame(interfere ? "R10" : "R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'((a * 53 + 29) ^ (a >> 2));
    mem[8'hE0] = 8'hFF; mem[8'hE1] = 8'h00; mem[8'hE2] = 8'hF0;
    mem[8'hE3] = 8'h81; mem[8'hE4] = 8'h0F;
    for (int r = 0; r < 32; r++) model[r] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy === 1'b0 && done === 1'b0 && collision === 1'b0, "R1", "flags after reset",
          {61'd0, busy, done, collision}, 64'd0);
    compare_frame("R1");

    draw(0, 0, 1, 12'h0E0, 1'b0);    // R4: bit 7 at column 0
    draw(0, 0, 1, 12'h0E1, 1'b0);    // R5/R8: zero byte over lit pixels
    draw(4, 0, 1, 12'h0E2, 1'b0);    // R8: erase columns 4..7
    draw(60, 5, 1, 12'h0E3, 1'b0);   // R6: bit 0 falls off right edge
    draw(70, 40, 2, 12'h0E0, 1'b0);  // R2: wrap to column 6, row 8
    draw(10, 30, 4, 12'h0E0, 1'b0);  // R7: rows 32,33 clipped
    draw(3, 3, 0, 12'h0E0, 1'b0);    // R11: empty draw
    draw(20, 12, 5, 12'h040, 1'b1);  // R10: start while busy
    draw(33, 17, 3, 12'hFFE, 1'b0);  // R3: address wraps at 4096
    draw(40, 20, 6, 12'h123, 1'b0);  // R8: first placement
    draw(40, 20, 6, 12'h123, 1'b0);  // R8: same sprite erases itself
    draw(63, 31, 15, 12'hE4, 1'b0);  // R6 R7: corner
    draw(255, 255, 2, 12'hE0, 1'b0); // R2: full-range wrap

    for (int k = 0; k < 96; k++) begin
      draw((k * 11) % 80, (k * 7) % 40, k % 16, (k * 29) & 12'hFFF, (k % 9) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule